// File: doc/BRIEF.md
# Byte-Serial Configurable Compute Array

This block evaluates a small, fixed dataflow tree on four 32-bit operands A, B, C and D and returns two 32-bit results. The first row holds two functional units: one combines A with B and one combines C with D. The second row holds one unit that combines the two first-row results. Each unit is set by a 3-bit opcode to add, subtract, AND, OR or XOR.

Every unit is only 8 bits wide. The block first evaluates the low byte of each operand. A width check then decides whether the rest of the word can change the answer. If it cannot, the operation ends after that single pass and the upper result bits are zero. If it can, the block steps its operand registers one byte at a time and runs three more passes. Each adder keeps its own carry between passes.

A request is made with a one-cycle `start` together with the configuration and the operands. The caller then waits for `done`.

Top module: `narrow_cfg_array`

## Requirements
- R1: After a synchronous reset, `busy` and `done` are low and `res1` and `res2` are zero. A reset in the middle of an operation returns the block to this state.
- R2: A `start` seen while `busy` is low is accepted. `busy` is high in the cycle after that edge.
- R3: Opcode values: 0 is add, 1 is subtract, 2 is AND, 3 is OR and 4 is XOR. Codes 5, 6 and 7 give a zero result and no carry.
- R4: When `done` is high, `res2` equals f1(A,B) and `res1` equals f3(f1(A,B), f2(C,D)), both modulo 2^32. Here f1 is selected by `cfg_f1`, f2 by `cfg_f2` and f3 by `cfg_f3`.
- R5: Subtract yields the two's-complement difference of the first operand minus the second, modulo 2^32. It is computed as the first operand plus the inverted second operand with an initial carry of 1.
- R6: If bits 31:8 of all four operands are zero and no add unit carries out of bit 7 and no subtract unit borrows out of bit 7 on the low-byte pass, the operation takes one pass. `done` is then high in the second cycle after the accepting edge, and bits 31:8 of both results are zero. In every other case exactly four passes run and `done` is high in the fifth cycle after the accepting edge.
- R7: The carry of each arithmetic unit crosses byte boundaries. This includes the carry of the second-row unit, whose inputs are the first-row results.
- R8: `done` is high for exactly one cycle. `busy` stays high from the cycle after the accepting edge up to, but not including, the `done` cycle. The two are never high together.
- R9: While `busy` is high, `start` and any change of the operands or the configuration have no effect on the results or on the pass count.
- R10: Outside an operation, `res1` and `res2` hold their last values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a new operation; sampled only when idle |
| cfg_f1 | input | 3 | Opcode of the row-1 unit on A and B |
| cfg_f2 | input | 3 | Opcode of the row-1 unit on C and D |
| cfg_f3 | input | 3 | Opcode of the row-2 unit |
| opa | input | 32 | Operand A |
| opb | input | 32 | Operand B |
| opc | input | 32 | Operand C |
| opd | input | 32 | Operand D |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: results are complete |
| res1 | output | 32 | Row-2 result |
| res2 | output | 32 | Row-1 result f1(A,B) |

## Verification
The hardest case to reach is an operation where the upper operand bytes are all zero but the result still needs four passes. This happens only when a low-byte carry or borrow leaks upward, and most often in the second-row adder, whose inputs are results the bench cannot drive directly. Directed vectors build this case on purpose: two first-row sums of 0x80 feed a second-row add, 0xFF is added to 1, and a small value has a larger one subtracted from it. Random operands whose width is picked per operand as one byte or a full word then mix short and long runs. Each run's pass count is compared against the rule in R6.

// File: rtl/nca_pkg.sv
package nca_pkg;

    typedef logic [2:0] opcode_t;

    localparam opcode_t OPC_ADD = 3'd0;
    localparam opcode_t OPC_SUB = 3'd1;
    localparam opcode_t OPC_AND = 3'd2;
    localparam opcode_t OPC_OR  = 3'd3;
    localparam opcode_t OPC_XOR = 3'd4;

    // number of functional units in the fixed tree: two in row 1, one in row 2
    localparam int NUM_FU = 3;
    localparam int NUM_OPND = 4;

    typedef enum logic {ST_IDLE, ST_RUN} run_state_e;

    function automatic logic is_arith(input opcode_t op);
        return (op == OPC_ADD) || (op == OPC_SUB);
    endfunction

    // carry fed into the low-byte pass: subtract starts with +1
    function automatic logic carry_seed(input opcode_t op);
        return (op == OPC_SUB);
    endfunction

endpackage

// File: rtl/nca_fu.sv
module nca_fu
    import nca_pkg::*;
#(
    parameter int W = 8
) (
    input  opcode_t        op,
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,
    input  logic           cin,
    output logic [W-1:0]   z,
    output logic           cout
);

    logic [W-1:0] y_eff;
    logic [W:0]   sum;

    always_comb begin
        y_eff = (op == OPC_SUB) ? ~y : y;
        sum   = {1'b0, x} + {1'b0, y_eff} + {{W{1'b0}}, cin};
        z     = '0;
        cout  = 1'b0;
        case (op)
            OPC_ADD, OPC_SUB: begin
                z    = sum[W-1:0];
                cout = sum[W];
            end
            OPC_AND: z = x & y;
            OPC_OR:  z = x | y;
            OPC_XOR: z = x ^ y;
            default: z = '0;
        endcase
    end

endmodule

// File: rtl/nca_width_check.sv
module nca_width_check
    import nca_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int SLICE_W = 8
) (
    input  logic [NUM_OPND-1:0][WORD_W-1:0] words,
    input  opcode_t [NUM_FU-1:0]            ops,
    input  logic [NUM_FU-1:0]               couts,
    output logic                            need_more
);

    logic upper_used;
    logic carry_leak;

    always_comb begin
        upper_used = 1'b0;
        for (int i = 0; i < NUM_OPND; i++) begin
            if (|words[i][WORD_W-1:SLICE_W]) upper_used = 1'b1;
        end
        carry_leak = 1'b0;
        for (int j = 0; j < NUM_FU; j++) begin
            // a carry that differs from its seed would alter the upper bytes
            if (is_arith(ops[j]) && (couts[j] != carry_seed(ops[j]))) carry_leak = 1'b1;
        end
        need_more = upper_used || carry_leak;
    end

endmodule

// File: rtl/nca_iter_ctrl.sv
module nca_iter_ctrl
    import nca_pkg::*;
#(
    parameter int NPASS = 4,
    parameter int PW    = (NPASS > 1) ? $clog2(NPASS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          need_more,
    output logic          busy,
    output logic          done,
    output logic          accept,
    output logic          iterate,
    output logic          first_pass,
    output logic [PW-1:0] pass_idx
);

    run_state_e    state_q;
    logic [PW-1:0] pass_q;
    logic          done_q;
    logic          finish;

    assign busy       = (state_q == ST_RUN);
    assign accept     = start && (state_q == ST_IDLE);
    assign first_pass = (pass_q == '0);
    assign pass_idx   = pass_q;
    assign finish     = busy && ((pass_q == PW'(NPASS - 1)) || (first_pass && !need_more));
    assign iterate    = busy && !finish;
    assign done       = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pass_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= finish;
            if (accept) begin
                state_q <= ST_RUN;
                pass_q  <= '0;
            end else if (finish) begin
                state_q <= ST_IDLE;
                pass_q  <= '0;
            end else if (iterate) begin
                pass_q <= pass_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/narrow_cfg_array.sv
module narrow_cfg_array
    import nca_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int SLICE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        cfg_f1,
    input  logic [2:0]        cfg_f2,
    input  logic [2:0]        cfg_f3,
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    input  logic [WORD_W-1:0] opc,
    input  logic [WORD_W-1:0] opd,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] res1,
    output logic [WORD_W-1:0] res2
);

    localparam int NPASS = WORD_W / SLICE_W;
    localparam int PW    = (NPASS > 1) ? $clog2(NPASS) : 1;

    // operand registers, shifted down one slice per pass
    logic [NUM_OPND-1:0][WORD_W-1:0] opnd_q;
    opcode_t [NUM_FU-1:0]            ops_q;
    logic [NUM_FU-1:0]               carry_q;
    logic [WORD_W-1:0]               res1_q, res2_q;

    logic [NUM_FU-1:0][SLICE_W-1:0]  fu_x, fu_y, fu_z;
    logic [NUM_FU-1:0]               fu_cin, fu_cout;

    logic          accept, iterate, first_pass, need_more;
    logic [PW-1:0] pass_idx;

    // tree wiring: unit 0 = f1(A,B), unit 1 = f2(C,D), unit 2 = f3(u0,u1)
    assign fu_x[0] = opnd_q[0][SLICE_W-1:0];
    assign fu_y[0] = opnd_q[1][SLICE_W-1:0];
    assign fu_x[1] = opnd_q[2][SLICE_W-1:0];
    assign fu_y[1] = opnd_q[3][SLICE_W-1:0];
    assign fu_x[2] = fu_z[0];
    assign fu_y[2] = fu_z[1];

    for (genvar g = 0; g < NUM_FU; g++) begin : g_fu
        assign fu_cin[g] = first_pass ? carry_seed(ops_q[g]) : carry_q[g];
        nca_fu #(.W(SLICE_W)) u_fu (
            .op   (ops_q[g]),
            .x    (fu_x[g]),
            .y    (fu_y[g]),
            .cin  (fu_cin[g]),
            .z    (fu_z[g]),
            .cout (fu_cout[g])
        );
    end

    nca_width_check #(.WORD_W(WORD_W), .SLICE_W(SLICE_W)) u_wchk (
        .words     (opnd_q),
        .ops       (ops_q),
        .couts     (fu_cout),
        .need_more (need_more)
    );

    nca_iter_ctrl #(.NPASS(NPASS), .PW(PW)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .need_more  (need_more),
        .busy       (busy),
        .done       (done),
        .accept     (accept),
        .iterate    (iterate),
        .first_pass (first_pass),
        .pass_idx   (pass_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            opnd_q  <= '0;
            ops_q   <= '0;
            carry_q <= '0;
            res1_q  <= '0;
            res2_q  <= '0;
        end else if (accept) begin
            opnd_q  <= {opd, opc, opb, opa};
            ops_q   <= {cfg_f3, cfg_f2, cfg_f1};
            carry_q <= '0;
            res1_q  <= '0;
            res2_q  <= '0;
        end else if (busy) begin
            res1_q[int'(pass_idx)*SLICE_W +: SLICE_W] <= fu_z[2];
            res2_q[int'(pass_idx)*SLICE_W +: SLICE_W] <= fu_z[0];
            carry_q <= fu_cout;
            if (iterate) begin
                for (int i = 0; i < NUM_OPND; i++) begin
                    opnd_q[i] <= opnd_q[i] >> SLICE_W;
                end
            end
        end
    end

    assign res1 = res1_q;
    assign res2 = res2_q;

endmodule

// File: rtl/nca_checker.sv
module nca_checker #(
    parameter int WORD_W  = 32,
    parameter int SLICE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [WORD_W-1:0] res1,
    input logic [WORD_W-1:0] res2
);

    localparam int NPASS = WORD_W / SLICE_W;

    logic [7:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (rst) busy_cnt <= '0;
        else if (start && !busy) busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + 8'd1;
    end

    assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    assert_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_pass_count_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> (busy_cnt == 8'd1 || busy_cnt == 8'(NPASS)));

    assert_short_upper_R6: assert property (@(posedge clk) disable iff (rst)
        (done && busy_cnt == 8'd1) |-> (res1[WORD_W-1:SLICE_W] == '0 && res2[WORD_W-1:SLICE_W] == '0));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(res1) && $stable(res2)));

endmodule

bind narrow_cfg_array nca_checker #(.WORD_W(WORD_W), .SLICE_W(SLICE_W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy  (busy),
    .done  (done),
    .res1  (res1),
    .res2  (res2)
);

// File: tb/tb_narrow_cfg_array.sv
`timescale 1ns/1ps
module tb_narrow_cfg_array;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  cfg_f1 = '0, cfg_f2 = '0, cfg_f3 = '0;
    logic [31:0] opa = '0, opb = '0, opc = '0, opd = '0;
    logic        busy, done;
    logic [31:0] res1, res2;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    narrow_cfg_array dut (
        .clk(clk), .rst(rst), .start(start),
        .cfg_f1(cfg_f1), .cfg_f2(cfg_f2), .cfg_f3(cfg_f3),
        .opa(opa), .opb(opb), .opc(opc), .opd(opd),
        .busy(busy), .done(done), .res1(res1), .res2(res2)
    );

    typedef struct packed {
        logic [2:0]  o1, o2, o3;
        logic [31:0] a, b, c, d;
        logic [31:0] e1, e2;
        logic        long_run;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 3'd3, 3'd0, 32'h1D, 32'h0C, 32'h20, 32'h08, 32'h51, 32'h29, 1'b0},
        '{3'd0, 3'd2, 3'd4, 32'hFF, 32'h01, 32'h00, 32'h00, 32'h100, 32'h100, 1'b1},
        '{3'd1, 3'd4, 3'd3, 32'h05, 32'h03, 32'h0F, 32'hF0, 32'hFF, 32'h02, 1'b0},
        '{3'd1, 3'd0, 3'd1, 32'h03, 32'h05, 32'h01, 32'h01, 32'hFFFFFFFC, 32'hFFFFFFFE, 1'b1},
        '{3'd2, 3'd3, 3'd0, 32'h12345678, 32'h0F0F0F0F, 32'h0, 32'h100, 32'h02040708, 32'h02040608, 1'b1},
        '{3'd4, 3'd4, 3'd4, 32'hAA, 32'h55, 32'h0F, 32'h0F, 32'hFF, 32'hFF, 1'b0},
        '{3'd0, 3'd0, 3'd0, 32'h80, 32'h00, 32'h80, 32'h00, 32'h100, 32'h80, 1'b1},
        '{3'd5, 3'd3, 3'd0, 32'h07, 32'h09, 32'h01, 32'h02, 32'h03, 32'h00, 1'b0}
    };

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_op(input logic [2:0] op, input logic [31:0] x, input logic [31:0] y);
        case (op)
            3'd0: return x + y;
            3'd1: return x - y;
            3'd2: return x & y;
            3'd3: return x | y;
            3'd4: return x ^ y;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic low_leak(input logic [2:0] op, input logic [7:0] x, input logic [7:0] y);
        if (op == 3'd0) return ({1'b0, x} + {1'b0, y}) > 9'd255;
        if (op == 3'd1) return x < y;
        return 1'b0;
    endfunction

    // R6 rule from the requirement
    function automatic logic ref_long(input logic [2:0] o1, o2, o3, input logic [31:0] a, b, c, d);
        logic [31:0] f1, f2;
        f1 = ref_op(o1, a, b);
        f2 = ref_op(o2, c, d);
        if ((a[31:8] | b[31:8] | c[31:8] | d[31:8]) != 24'h0) return 1'b1;
        return low_leak(o1, a[7:0], b[7:0]) || low_leak(o2, c[7:0], d[7:0]) || low_leak(o3, f1[7:0], f2[7:0]);
    endfunction

    task automatic run_op(input logic [2:0] o1, o2, o3, input logic [31:0] a, b, c, d,
                          output logic [31:0] r1, output logic [31:0] r2, output int cyc);
        @(negedge clk);
        cfg_f1 = o1; cfg_f2 = o2; cfg_f3 = o3;
        opa = a; opb = b; opc = c; opd = d;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 20) begin
            @(negedge clk);
            cyc++;
        end
        r1 = res1;
        r2 = res2;
    endtask

    initial begin : watchdog
        #(20ns * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [31:0] r1, r2, e1, e2, k1;
        int cyc, ecyc;
        logic [2:0] o1, o2, o3;
        logic [31:0] a, b, c, d;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!busy && !done, "R1 busy/done after reset", {30'b0, busy, done}, 32'h0);
        check(res1 == 0 && res2 == 0, "R1 results after reset", res1 | res2, 32'h0);

        // table of vectors: R3 R4 R5 R6 R7
        for (int i = 0; i < NVEC; i++) begin
            run_op(VECS[i].o1, VECS[i].o2, VECS[i].o3, VECS[i].a, VECS[i].b, VECS[i].c, VECS[i].d, r1, r2, cyc);
            ecyc = VECS[i].long_run ? 5 : 2;
            check(r1 == VECS[i].e1, "R4/R5/R7/R3 res1 vector", r1, VECS[i].e1);
            check(r2 == VECS[i].e2, "R4/R5/R3 res2 vector", r2, VECS[i].e2);
            check(cyc == ecyc, "R6 pass count vector", cyc, ecyc);
        end

        // R2: busy seen one cycle after accept
        @(negedge clk);
        cfg_f1 = 3'd0; cfg_f2 = 3'd0; cfg_f3 = 3'd0;
        opa = 32'h100; opb = 32'h1; opc = 32'h2; opd = 32'h3;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy && !done, "R2 busy after start", {30'b0, busy, done}, 32'h2);
        // R9: new start and operands mid-run are ignored
        @(negedge clk);
        start = 1'b1;
        opa = 32'h5; opb = 32'h5; cfg_f1 = 3'd2;
        @(negedge clk);
        start = 1'b0;
        cyc = 3;
        while (!done && cyc < 20) begin
            @(negedge clk);
            cyc++;
        end
        check(res1 == 32'h106, "R9 res1 ignores mid-run changes", res1, 32'h106);
        check(res2 == 32'h101, "R9 res2 ignores mid-run changes", res2, 32'h101);
        check(cyc == 5, "R9 pass count unaffected", cyc, 5);
        // R8: done one cycle wide, busy low with it
        check(!busy, "R8 busy low during done", {31'b0, busy}, 32'h0);
        @(negedge clk);
        check(!done && !busy, "R8 done single cycle", {30'b0, busy, done}, 32'h0);

        // R10: outputs hold without start
        k1 = res1;
        opa = 32'hDEAD; opb = 32'hBEEF; cfg_f3 = 3'd4;
        repeat (4) @(negedge clk);
        check(res1 == k1 && res2 == 32'h101, "R10 hold res1", res1, k1);

        // random mix
        for (int n = 0; n < 60; n++) begin
            o1 = 3'($urandom_range(0, 4));
            o2 = 3'($urandom_range(0, 4));
            o3 = 3'($urandom_range(0, 4));
            a = $urandom & (($urandom % 2) ? 32'hFFFFFFFF : 32'hFF);
            b = $urandom & (($urandom % 2) ? 32'hFFFFFFFF : 32'hFF);
            c = $urandom & (($urandom % 3 == 0) ? 32'hFFFFFFFF : 32'hFF);
            d = $urandom & (($urandom % 3 == 0) ? 32'hFFFFFFFF : 32'hFF);
            run_op(o1, o2, o3, a, b, c, d, r1, r2, cyc);
            e2 = ref_op(o1, a, b);
            e1 = ref_op(o3, e2, ref_op(o2, c, d));
            ecyc = ref_long(o1, o2, o3, a, b, c, d) ? 5 : 2;
            check(r1 == e1, "R4 random res1", r1, e1);
            check(r2 == e2, "R4 random res2", r2, e2);
            check(cyc == ecyc, "R6 random pass count", cyc, ecyc);
        end

        // R1: reset during an operation
        @(negedge clk);
        cfg_f1 = 3'd0; opa = 32'hFFFF; opb = 32'h1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(!busy && !done && res1 == 0 && res2 == 0, "R1 mid-run reset", res1 | res2 | {30'b0, busy, done}, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule